// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Non-Volatile Store Controller

This block holds the register state behind a 128-step digital potentiometer: a 7-bit wiper code that drives the tap selection, a 7-bit start-up value that stands in for an EEPROM cell, and an 8-bit control register. A serial slave in front of it turns bus frames into single-cycle register write and read strobes, plus a strobe that marks the chip select returning high. The block answers with registered read data, the current wiper code and a shutdown flag for the analog switches.

At power-up the wiper sits at mid-scale. Once the supply is reported good, the stored start-up value is copied into the wiper. A mode bit in the control register decides where a write to pointer 0 lands. In non-volatile mode the write updates both the stored value and the wiper, and it arms a self-timed programming cycle. That cycle begins when the chip select rises, and while it runs the wiper and the control register refuse writes. Shutdown comes from an active-low pin or from a control bit. Either source opens the switches but keeps the wiper code.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While `pwrGood` is low, the wiper code is forced to mid-scale (40h), the control register returns to its defaults (mode bit 0, shutdown bit 1), and register writes are ignored. The stored start-up value is kept.
- R2: On the first clock edge with `pwrGood` high after reset or after a supply loss, the wiper code is loaded from the stored start-up value.
- R3: Pointer 2 is the control register. Its bit 7 is the mode bit, bit 6 is the shutdown-enable bit (1 = run), bit 5 reads the write-busy flag, and bits 4:0 read as zero. A write to bit 5 has no effect. Pointers 1 and 3 ignore writes and read as 00h.
- R4: With the mode bit at 0, a write to pointer 0 loads bits 6:0 of the data into both the stored value and the wiper code, and a read of pointer 0 returns the stored value, zero-extended.
- R5: With the mode bit at 1, a write to pointer 0 changes only the wiper code, and a read of pointer 0 returns the wiper code, zero-extended.
- R6: After a non-volatile write, the busy flag stays 0 until `csRise`. It then reads 1 for exactly `NV_CYCLES` clock cycles, counted from the edge that samples `csRise`, and returns to 0.
- R7: While the busy flag is 1, writes to pointer 0 and to the control register are rejected.
- R8: `shutdown` is 1 when `shdnPinN` is low or the shutdown-enable bit is 0. The wiper code does not change on entry to or exit from shutdown.
- R9: Reading the stored value does not change the wiper code.
- R10: All registers remain writable and readable while `shutdown` is 1.
- R11: Read data is registered. `regRdData` shows the value selected by `regAddr` one clock after `regRdEn` is sampled, and it holds that value while `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; also sets the stored value to `IVR_INIT` |
| pwrGood | input | 1 | Supply good; low holds the wiper at mid-scale |
| shdnPinN | input | 1 | Active-low shutdown pin |
| regAddr | input | 2 | Register pointer for writes and reads |
| regWrEn | input | 1 | One-cycle write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | One-cycle read strobe |
| csRise | input | 1 | Chip select has returned high; starts a pending programming cycle |
| wiperCode | output | 7 | Current wiper tap code |
| shutdown | output | 1 | Switches open, wiper terminal grounded |
| regRdData | output | 8 | Registered read data |

## Verification
The bench builds the block with `NV_CYCLES` = 8 instead of the default one million cycles, which are 20 ms at the system clock. This makes the full length of the busy window observable cycle by cycle, including the clock where it ends. It also lets a test issue wiper and control writes inside the window and then confirm, once the window closes, that they were rejected. `IVR_INIT` is set to 15h, which differs from mid-scale, so the recall after power-up and after a supply loss is visible on the wiper code.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int ADDR_W = 2;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] PTR_WIPER = 2'd0;
  localparam logic [ADDR_W-1:0] PTR_CTRL  = 2'd2;

  localparam int CTRL_MODE_BIT = 7;
  localparam int CTRL_RUN_BIT  = 6;
  localparam int CTRL_BUSY_BIT = 5;

  typedef struct packed {
    logic forceMid;
    logic recall;
    logic loadWiper;
    logic loadStore;
    logic loadCtrl;
  } regStrobes_t;

endpackage

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int NV_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic abort,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (abort) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CNT_LOAD;
    end else if (busy) begin
      if (remain == CNT_LAST) begin
        busy   <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - CNT_LAST;
      end
    end
  end

endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              csRise,
  input  logic              modeVol,
  input  logic              nvBusy,
  output regStrobes_t       stb,
  output logic              startNv
);

  logic recalled;
  logic nvPending;
  logic accessOk;
  logic wrPointer0;

  assign accessOk   = pwrGood && recalled;
  assign wrPointer0 = accessOk && regWrEn && (regAddr == PTR_WIPER) && !nvBusy;

  always_comb begin
    stb           = '0;
    stb.forceMid  = !pwrGood;
    stb.recall    = pwrGood && !recalled;
    stb.loadWiper = wrPointer0;
    stb.loadStore = wrPointer0 && !modeVol;
    stb.loadCtrl  = accessOk && regWrEn && (regAddr == PTR_CTRL) && !nvBusy;
  end

  assign startNv = pwrGood && nvPending && csRise && !nvBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recalled <= 1'b0;
    end else begin
      recalled <= pwrGood;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvPending <= 1'b0;
    end else if (!pwrGood) begin
      nvPending <= 1'b0;
    end else if (startNv) begin
      nvPending <= 1'b0;
    end else if (stb.loadStore) begin
      nvPending <= 1'b1;
    end
  end

endmodule

// File: rtl/dpot_datapath.sv
module dpot_datapath
  import dpot_pkg::*;
#(
  parameter int              WIPER_W  = 7,
  parameter logic [WIPER_W-1:0] IVR_INIT = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        stb,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               nvBusy,
  input  logic               shdnPinN,
  output logic [WIPER_W-1:0] wiperCode,
  output logic               modeVol,
  output logic               shutdown,
  output logic [REG_W-1:0]   regRdData
);

  localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);
  localparam int PAD_W = REG_W - WIPER_W;

  logic [WIPER_W-1:0] storeVal;
  logic               runEn;
  logic [REG_W-1:0]   ctrlView;
  logic [REG_W-1:0]   ptr0View;
  logic [REG_W-1:0]   rdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeVal <= IVR_INIT;
    end else if (stb.loadStore) begin
      storeVal <= regWrData[WIPER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiperCode <= MID_CODE;
    end else if (stb.forceMid) begin
      wiperCode <= MID_CODE;
    end else if (stb.recall) begin
      wiperCode <= storeVal;
    end else if (stb.loadWiper) begin
      wiperCode <= regWrData[WIPER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeVol <= 1'b0;
      runEn   <= 1'b1;
    end else if (stb.forceMid) begin
      modeVol <= 1'b0;
      runEn   <= 1'b1;
    end else if (stb.loadCtrl) begin
      modeVol <= regWrData[CTRL_MODE_BIT];
      runEn   <= regWrData[CTRL_RUN_BIT];
    end
  end

  assign shutdown = !shdnPinN || !runEn;

  always_comb begin
    ctrlView = '0;
    ctrlView[CTRL_MODE_BIT] = modeVol;
    ctrlView[CTRL_RUN_BIT]  = runEn;
    ctrlView[CTRL_BUSY_BIT] = nvBusy;
  end

  assign ptr0View = modeVol ? {{PAD_W{1'b0}}, wiperCode} : {{PAD_W{1'b0}}, storeVal};

  always_comb begin
    case (regAddr)
      PTR_WIPER: rdSel = ptr0View;
      PTR_CTRL:  rdSel = ctrlView;
      default:   rdSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (regRdEn) begin
      regRdData <= rdSel;
    end
  end

endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
  import dpot_pkg::*;
#(
  parameter int                 WIPER_W   = 7,
  parameter int                 NV_CYCLES = 1000000,
  parameter logic [WIPER_W-1:0] IVR_INIT  = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic               shdnPinN,
  input  logic [1:0]         regAddr,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic               regRdEn,
  input  logic               csRise,
  output logic [WIPER_W-1:0] wiperCode,
  output logic               shutdown,
  output logic [7:0]         regRdData
);

  regStrobes_t stb;
  logic        startNv;
  logic        nvBusy;
  logic        modeVol;

  dpot_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrGood (pwrGood),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .csRise  (csRise),
    .modeVol (modeVol),
    .nvBusy  (nvBusy),
    .stb     (stb),
    .startNv (startNv)
  );

  dpot_nv_timer #(.NV_CYCLES(NV_CYCLES)) i_timer (
    .clk   (clk),
    .rstN  (rstN),
    .abort (!pwrGood),
    .start (startNv),
    .busy  (nvBusy)
  );

  dpot_datapath #(.WIPER_W(WIPER_W), .IVR_INIT(IVR_INIT)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .nvBusy    (nvBusy),
    .shdnPinN  (shdnPinN),
    .wiperCode (wiperCode),
    .modeVol   (modeVol),
    .shutdown  (shutdown),
    .regRdData (regRdData)
  );

endmodule

// File: rtl/dpot_checker.sv
module dpot_checker #(
  parameter int WIPER_W   = 7,
  parameter int NV_CYCLES = 1000000
) (
  input logic               clk,
  input logic               rstN,
  input logic               pwrGood,
  input logic               shdnPinN,
  input logic               regWrEn,
  input logic [WIPER_W-1:0] wiperCode,
  input logic               shutdown,
  input logic               nvBusy
);

  localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);
  localparam int BW = $clog2(NV_CYCLES + 2);

  logic [BW-1:0] busyLen;
  logic [1:0]    sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= '0;
    end else if (nvBusy) begin
      busyLen <= busyLen + BW'(1);
    end else begin
      busyLen <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != 2'd3) begin
      sinceRst <= sinceRst + 2'd1;
    end
  end

  // R1: supply not good puts the wiper at mid-scale
  a_r1_mid_when_down: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> wiperCode == MID_CODE);

  // R8: the pin alone is enough to shut down
  a_r8_pin_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    !shdnPinN |-> shutdown);

  // R7: no wiper change while a programming cycle runs
  a_r7_busy_freezes_wiper: assert property (@(posedge clk) disable iff (!rstN)
    (nvBusy && pwrGood) |=> $stable(wiperCode));

  // R6: busy window has the configured length
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nvBusy) && pwrGood && $past(pwrGood)) |-> busyLen == BW'(NV_CYCLES));

  // R8: with steady supply and no write, the wiper holds
  a_r8_wiper_held: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && pwrGood && $past(pwrGood) && $past(pwrGood, 2) && !$past(regWrEn))
      |-> $stable(wiperCode));

endmodule

bind wiper_nv_ctrl dpot_checker #(.WIPER_W(WIPER_W), .NV_CYCLES(NV_CYCLES)) i_dpot_checker (
  .clk       (clk),
  .rstN      (rstN),
  .pwrGood   (pwrGood),
  .shdnPinN  (shdnPinN),
  .regWrEn   (regWrEn),
  .wiperCode (wiperCode),
  .shutdown  (shutdown),
  .nvBusy    (nvBusy)
);

// File: tb/test_wiper_nv_ctrl.sv
`timescale 1ns/1ps
module test_wiper_nv_ctrl;

  localparam int         NVC  = 8;
  localparam logic [6:0] INIT = 7'h15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b0;
  logic       shdnPinN = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       regRdEn = 1'b0;
  logic       csRise = 1'b0;
  logic [6:0] wiperCode;
  logic       shutdown;
  logic [7:0] regRdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wiper_nv_ctrl #(.WIPER_W(7), .NV_CYCLES(NVC), .IVR_INIT(INIT)) i_wiper_nv_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .shdnPinN(shdnPinN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .csRise(csRise), .wiperCode(wiperCode),
    .shutdown(shutdown), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulseCs();
    @(negedge clk);
    csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (NVC + 2) @(negedge clk);
  endtask

  task automatic testPowerUp();
    logic [7:0] d;
    rstN = 1'b0; pwrGood = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mid-scale after reset", {1'b0, wiperCode}, 8'h40);
    check("R8 no shutdown at reset", {7'b0, shutdown}, 8'h00);
    wrReg(2'd2, 8'h80);
    rdReg(2'd2, d);
    check("R1 write ignored while supply down", d, 8'h40);
    @(negedge clk);
    pwrGood = 1'b1;
    @(negedge clk);
    check("R2 recall on power good", {1'b0, wiperCode}, {1'b0, INIT});
  endtask

  task automatic testCtrlLayout();
    logic [7:0] d;
    rdReg(2'd2, d);
    check("R3 control defaults", d, 8'h40);
    wrReg(2'd2, 8'hFF);
    rdReg(2'd2, d);
    check("R3 busy bit and low bits not writable", d, 8'hC0);
    wrReg(2'd1, 8'h33);
    wrReg(2'd3, 8'h00);
    rdReg(2'd1, d);
    check("R3 pointer 1 reads zero", d, 8'h00);
    rdReg(2'd3, d);
    check("R3 pointer 3 reads zero", d, 8'h00);
    rdReg(2'd2, d);
    check("R3 pointer 3 write ignored", d, 8'hC0);
    check("R3 stray writes leave wiper", {1'b0, wiperCode}, {1'b0, INIT});
  endtask

  task automatic testVolatileMode();
    logic [7:0] d;
    wrReg(2'd0, 8'hAA);
    check("R5 volatile write reaches wiper", {1'b0, wiperCode}, 8'h2A);
    rdReg(2'd0, d);
    check("R5 pointer 0 reads wiper", d, 8'h2A);
    wrReg(2'd2, 8'h40);
    rdReg(2'd0, d);
    check("R5 stored value untouched", d, {1'b0, INIT});
    check("R9 reading stored value keeps wiper", {1'b0, wiperCode}, 8'h2A);
    @(negedge clk);
    check("R11 read data holds without strobe", regRdData, {1'b0, INIT});
  endtask

  task automatic testNvWrite();
    logic [7:0] d;
    wrReg(2'd0, 8'h77);
    check("R4 nv write updates wiper", {1'b0, wiperCode}, 8'h77);
    rdReg(2'd2, d);
    check("R6 busy low before cs rise", d, 8'h40);
    @(negedge clk);
    csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0;
    regAddr = 2'd2; regRdEn = 1'b1;
    for (int k = 1; k <= NVC + 1; k++) begin
      @(negedge clk);
      check($sformatf("R6 busy flag cycle %0d", k), {7'b0, regRdData[5]},
            (k <= NVC) ? 8'h01 : 8'h00);
    end
    regRdEn = 1'b0;
    rdReg(2'd0, d);
    check("R4 pointer 0 reads stored value", d, 8'h77);
  endtask

  task automatic testBusyBlocks();
    logic [7:0] d;
    wrReg(2'd0, 8'h05);
    pulseCs();
    wrReg(2'd2, 8'h80);
    wrReg(2'd0, 8'h11);
    check("R7 wiper write rejected when busy", {1'b0, wiperCode}, 8'h05);
    waitIdle();
    rdReg(2'd2, d);
    check("R7 control write rejected when busy", d, 8'h40);
    rdReg(2'd0, d);
    check("R7 stored value kept when busy", d, 8'h05);
  endtask

  task automatic testShutdown();
    logic [7:0] d;
    @(negedge clk);
    shdnPinN = 1'b0;
    #1;
    check("R8 pin shutdown", {7'b0, shutdown}, 8'h01);
    check("R8 wiper kept in pin shutdown", {1'b0, wiperCode}, 8'h05);
    @(negedge clk);
    shdnPinN = 1'b1;
    #1;
    check("R8 pin released", {7'b0, shutdown}, 8'h00);
    wrReg(2'd2, 8'h80);
    check("R8 bit shutdown", {7'b0, shutdown}, 8'h01);
    wrReg(2'd0, 8'h3C);
    check("R10 wiper write in shutdown", {1'b0, wiperCode}, 8'h3C);
    rdReg(2'd0, d);
    check("R10 wiper read in shutdown", d, 8'h3C);
    wrReg(2'd2, 8'hC0);
    check("R8 bit shutdown released", {7'b0, shutdown}, 8'h00);
    check("R8 wiper kept after shutdown", {1'b0, wiperCode}, 8'h3C);
  endtask

  task automatic testPowerLoss();
    logic [7:0] d;
    @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    check("R1 mid-scale on supply loss", {1'b0, wiperCode}, 8'h40);
    rdReg(2'd2, d);
    check("R1 control defaults on supply loss", d, 8'h40);
    @(negedge clk);
    pwrGood = 1'b1;
    @(negedge clk);
    check("R2 recall keeps stored value", {1'b0, wiperCode}, 8'h05);
  endtask

  initial begin
    testPowerUp();
    testCtrlLayout();
    testVolatileMode();
    testNvWrite();
    testBusyBlocks();
    testShutdown();
    testPowerLoss();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule